// File: doc/BRIEF.md
# USB Low/Full-Speed Serial Line Decoder

This block turns the sampled levels of a USB data pair into packet bytes. A recovery stage ahead of it presents one sample of D+ and D- per bit time, marked by a one-cycle strobe. The decoder classifies each sample as a J, K, SE0 or SE1 line state, using the polarity that matches the selected speed. While idle it hunts for the synchronisation pattern. Inside a packet it undoes NRZI coding and removes stuffed bits, then packs bits into bytes least significant bit first.

The first byte of a packet is the packet identifier. It is checked by its complementary nibbles, and a packet with a bad identifier yields no bytes at all. The decoder holds each completed byte back by one byte. As a result, the end-of-packet flag that follows two SE0 bit times leaves together with the final complete byte, and any trailing partial byte is dropped. Consumers see a byte stream with valid, start and end flags, plus single-cycle error pulses for a bad identifier or a stuffing violation.

Top module: `usb_line_rx`

## Requirements
- R1: The line state is SE0 for D+=0,D-=0 and SE1 for D+=1,D-=1. At full speed (`low_speed_i`=0), J is D+=1,D-=0 and K is D+=0,D-=1. At low speed (`low_speed_i`=1), J and K are swapped.
- R2: A packet starts only after eight consecutive J/K samples read K,J,K,J,K,J,K,K, oldest first, while no packet is open. Idle J produces no output.
- R3: Within a packet, a sample that differs from the previous J/K state decodes as 0, and an equal one decodes as 1. Decoded bits fill each byte starting at bit 0.
- R4: After six consecutive decoded 1s, the next sample is a stuffed 0 and is removed from the data. The final 1 of the synchronisation pattern counts toward that run.
- R5: A decoded 1 where a stuffed 0 is due raises `stuff_err_o` for one cycle. The packet then yields no further bytes and no end flag.
- R6: The first byte is a valid identifier only if bits [7:4] equal the inverse of bits [3:0]. Otherwise `pid_err_o` pulses and no byte or end flag is produced for that packet.
- R7: Each complete byte of a packet with a valid identifier appears on `byte_o` with `byte_valid_o`. `sop_o` is set only with the identifier byte.
- R8: Two consecutive SE0 samples end the packet. `eop_o` pulses in the same cycle as the last complete byte, and the hunt for the next packet resumes.
- R9: Bits of an incomplete byte pending at the end of a packet are discarded with no error flag.
- R10: An SE1 sample, or a single SE0 followed by J or K, abandons the packet silently: no byte, no end flag and no error flag until the next two-SE0 end.
- R11: All outputs are low in reset. Every flag is a one-cycle pulse in the clock cycle after the strobe that sampled the deciding symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe, one per bit time |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| byte_o | output | 8 | Decoded byte |
| byte_valid_o | output | 1 | `byte_o` carries a packet byte |
| sop_o | output | 1 | Byte is the first of its packet |
| eop_o | output | 1 | Packet ended |
| pid_err_o | output | 1 | Identifier check failed |
| stuff_err_o | output | 1 | Bit-stuffing violation |

## Verification
The assertions assume that `bit_en_i` is a single-cycle strobe. They also assume that D+, D- and `low_speed_i` are steady at the clock edge where the strobe is high, and that the speed select does not change inside a packet. The stimulus drives each symbol on a falling edge and holds it for four clocks with the strobe high for the first one only. It changes the speed select only while the line idles between packets.

// File: rtl/usb_line_rx_pkg.sv
package usb_line_rx_pkg;
  typedef enum logic [1:0] {LN_SE0, LN_J, LN_K, LN_SE1} line_e;
  typedef enum logic [1:0] {ST_HUNT, ST_RECV, ST_DROP} rx_state_e;
endpackage

// File: rtl/usb_line_rx_sym.sv
module usb_line_rx_sym
  import usb_line_rx_pkg::*;
(
  input  logic  dp_i,
  input  logic  dm_i,
  input  logic  low_speed_i,
  output line_e line_o
);
  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   line_o = LN_SE0;
      2'b11:   line_o = LN_SE1;
      2'b10:   line_o = low_speed_i ? LN_K : LN_J;
      default: line_o = low_speed_i ? LN_J : LN_K;
    endcase
  end
endmodule

// File: rtl/usb_line_rx_sync.sv
module usb_line_rx_sync
  import usb_line_rx_pkg::*;
#(
  parameter int SYNC_LEN = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_en_i,
  input  line_e line_i,
  output logic  hit_o
);
  localparam int HW = SYNC_LEN - 1;

  // newest symbol at bit 0: K,K then alternating J,K going older
  function automatic logic [SYNC_LEN-1:0] sync_pat();
    logic [SYNC_LEN-1:0] p;
    for (int i = 0; i < SYNC_LEN; i++) p[i] = (i == 0) || (i % 2 == 1);
    return p;
  endfunction
  localparam logic [SYNC_LEN-1:0] PAT = sync_pat();

  logic [HW-1:0] hist_k_q, hist_ok_q;
  logic [SYNC_LEN-1:0] full_k, full_ok;

  assign full_k  = {hist_k_q, line_i == LN_K};
  assign full_ok = {hist_ok_q, (line_i == LN_K) || (line_i == LN_J)};
  assign hit_o   = (&full_ok) && (full_k == PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_k_q  <= '0;
      hist_ok_q <= '0;
    end else if (bit_en_i) begin
      hist_k_q  <= full_k[HW-1:0];
      hist_ok_q <= full_ok[HW-1:0];
    end
  end
endmodule

// File: rtl/usb_line_rx_nrzi.sv
module usb_line_rx_nrzi
  import usb_line_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_en_i,
  input  line_e line_i,
  input  logic  start_i,
  input  logic  run_i,
  output logic  bit_o,
  output logic  bit_valid_o,
  output logic  stuff_err_o
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic             prev_k_q;
  logic [RUN_W-1:0] ones_q;
  logic             is_jk, cur_k, at_limit;

  assign cur_k       = (line_i == LN_K);
  assign is_jk       = cur_k || (line_i == LN_J);
  assign bit_o       = (cur_k == prev_k_q);
  assign at_limit    = (ones_q == RUN_W'(STUFF_RUN));
  assign bit_valid_o = run_i && is_jk && !at_limit;
  assign stuff_err_o = run_i && is_jk && at_limit && bit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_k_q <= 1'b0;
      ones_q   <= '0;
    end else if (bit_en_i) begin
      if (start_i) begin
        prev_k_q <= 1'b1;          // sync ends on K with a decoded 1
        ones_q   <= RUN_W'(1);
      end else if (run_i && is_jk) begin
        prev_k_q <= cur_k;
        if (at_limit)   ones_q <= '0;
        else if (bit_o) ones_q <= ones_q + RUN_W'(1);
        else            ones_q <= '0;
      end
    end
  end

  a_r4_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_W'(STUFF_RUN));
endmodule

// File: rtl/usb_line_rx.sv
module usb_line_rx
  import usb_line_rx_pkg::*;
#(
  parameter int SYNC_LEN  = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       pid_err_o,
  output logic       stuff_err_o
);
  localparam int CNT_W = 3;
  localparam int SE0_W = $clog2(EOP_SE0 + 1);

  line_e            line;
  rx_state_e        state_q;
  logic             sync_hit, dbit, dbit_valid, stuff_bad;
  logic [6:0]       sh_q;
  logic [7:0]       nxt_byte, pend_q;
  logic             pend_v_q, pend_first_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SE0_W-1:0] se0_q;
  logic             se0_last;

  function automatic logic pid_ok(input logic [7:0] b);
    return b[7:4] == ~b[3:0];
  endfunction

  usb_line_rx_sym u_sym (
    .dp_i(dp_i), .dm_i(dm_i), .low_speed_i(low_speed_i), .line_o(line)
  );

  usb_line_rx_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .line_i(line), .hit_o(sync_hit)
  );

  usb_line_rx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .line_i(line),
    .start_i(state_q == ST_HUNT && sync_hit),
    .run_i(state_q == ST_RECV),
    .bit_o(dbit), .bit_valid_o(dbit_valid), .stuff_err_o(stuff_bad)
  );

  assign nxt_byte = {dbit, sh_q};
  assign se0_last = (se0_q == SE0_W'(EOP_SE0 - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_HUNT;
      sh_q         <= '0;
      cnt_q        <= '0;
      pend_q       <= '0;
      pend_v_q     <= 1'b0;
      pend_first_q <= 1'b0;
      se0_q        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      sop_o        <= 1'b0;
      eop_o        <= 1'b0;
      pid_err_o    <= 1'b0;
      stuff_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      sop_o        <= 1'b0;
      eop_o        <= 1'b0;
      pid_err_o    <= 1'b0;
      stuff_err_o  <= 1'b0;
      if (bit_en_i) begin
        unique case (state_q)
          ST_HUNT: if (sync_hit) begin
            state_q  <= ST_RECV;
            cnt_q    <= '0;
            pend_v_q <= 1'b0;
            se0_q    <= '0;
          end
          ST_RECV: begin
            if (line == LN_SE0) begin
              if (se0_last) begin
                eop_o        <= 1'b1;
                byte_o       <= pend_q;
                byte_valid_o <= pend_v_q;
                sop_o        <= pend_v_q && pend_first_q;
                se0_q        <= '0;
                state_q      <= ST_HUNT;
              end else begin
                se0_q <= se0_q + SE0_W'(1);
              end
            end else if (line == LN_SE1 || se0_q != '0) begin
              se0_q   <= '0;
              state_q <= ST_DROP;
            end else if (stuff_bad) begin
              stuff_err_o <= 1'b1;
              state_q     <= ST_DROP;
            end else if (dbit_valid) begin
              if (cnt_q == CNT_W'(7)) begin
                cnt_q <= '0;
                if (!pend_v_q) begin
                  if (pid_ok(nxt_byte)) begin
                    pend_q       <= nxt_byte;
                    pend_v_q     <= 1'b1;
                    pend_first_q <= 1'b1;
                  end else begin
                    pid_err_o <= 1'b1;
                    state_q   <= ST_DROP;
                  end
                end else begin
                  byte_o       <= pend_q;
                  byte_valid_o <= 1'b1;
                  sop_o        <= pend_first_q;
                  pend_q       <= nxt_byte;
                  pend_first_q <= 1'b0;
                end
              end else begin
                sh_q  <= nxt_byte[7:1];
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end
          ST_DROP: begin
            if (line == LN_SE0) begin
              if (se0_last) begin
                se0_q   <= '0;
                state_q <= ST_HUNT;
              end else begin
                se0_q <= se0_q + SE0_W'(1);
              end
            end else begin
              se0_q <= '0;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  a_r11_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || eop_o || pid_err_o || stuff_err_o) |-> $past(bit_en_i));
  a_r7_sop_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> byte_valid_o);
  a_r6_pid_err_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_err_o |-> !byte_valid_o && !eop_o && !stuff_err_o);
  a_r5_stuff_err_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_err_o |-> !byte_valid_o && !eop_o);
  a_r8_eop_rehunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> state_q == ST_HUNT);
endmodule

// File: tb/usb_line_rx_tb.sv
module usb_line_rx_tb;
  logic clk = 1'b0, rst_ni = 1'b0, bit_en = 1'b0;
  logic dp = 1'b1, dm = 1'b0, ls = 1'b0;
  logic [7:0] byte_o;
  logic byte_valid_o, sop_o, eop_o, pid_err_o, stuff_err_o;

  always #10 clk = ~clk;  // 50 MHz

  usb_line_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .dp_i(dp), .dm_i(dm),
    .low_speed_i(ls), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .sop_o(sop_o), .eop_o(eop_o), .pid_err_o(pid_err_o), .stuff_err_o(stuff_err_o)
  );

  int n_chk = 0, n_err = 0;
  int cap_n = 0, pid_n = 0, stf_n = 0, eop_n = 0, pulse_bad = 0;
  logic [7:0] cap_byte [256];
  logic cap_sop [256];
  logic cap_eop [256];
  logic en_at_pos = 1'b0, prev_any = 1'b0;

  always @(posedge clk) en_at_pos <= bit_en;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (byte_valid_o && cap_n < 256) begin
        cap_byte[cap_n] = byte_o;
        cap_sop[cap_n]  = sop_o;
        cap_eop[cap_n]  = eop_o;
        cap_n++;
      end
      if (pid_err_o) pid_n++;
      if (stuff_err_o) stf_n++;
      if (eop_o) eop_n++;
      if ((byte_valid_o || eop_o || pid_err_o || stuff_err_o || sop_o) && (!en_at_pos || prev_any))
        pulse_bad++;
      prev_any = byte_valid_o || eop_o || pid_err_o || stuff_err_o || sop_o;
    end
  end

  // {len, extra bits, b0, b1, b2, b3}
  localparam logic [39:0] VEC [7] = '{
    40'h10_D2000000, 40'h40_C3FF007E, 40'h30_69810A00, 40'h30_55123400,
    40'h23_4BA50000, 40'h40_4BFFFFFF, 40'h25_E1000000
  };

  logic [7:0] pkt [4];
  logic lvl_k = 1'b0;
  int ones = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sym(input int s);  // 0 SE0, 1 J, 2 K, 3 SE1
    @(negedge clk);
    case (s)
      0: {dp, dm} = 2'b00;
      3: {dp, dm} = 2'b11;
      1: {dp, dm} = ls ? 2'b01 : 2'b10;
      default: {dp, dm} = ls ? 2'b10 : 2'b01;
    endcase
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_sync();
    sym(1);
    for (int i = 0; i < 3; i++) begin sym(2); sym(1); end
    sym(2); sym(2);
    lvl_k = 1'b1;
    ones = 1;
  endtask

  task automatic send_raw(input logic b);
    if (!b) lvl_k = !lvl_k;
    sym(lvl_k ? 2 : 1);
  endtask

  task automatic send_bit(input logic b);
    send_raw(b);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin
      send_raw(1'b0);
      ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_eop();
    sym(0); sym(0); sym(1); sym(1); sym(1);
  endtask

  task automatic check_pkt(input string req, input int c0, input int p0, input int s0,
                           input int e0, input int n, input int pe, input int se);
    chk({req, " byte count"}, cap_n - c0, n);
    for (int i = 0; i < n && c0 + i < cap_n; i++) begin
      chk({req, " byte value"}, cap_byte[c0+i], pkt[i]);
      chk({req, " sop flag"}, cap_sop[c0+i], i == 0);
      chk({req, " eop with last byte"}, cap_eop[c0+i], i == n - 1);
    end
    chk({req, " eop count"}, eop_n - e0, n > 0);
    chk({req, " pid_err count"}, pid_n - p0, pe);
    chk({req, " stuff_err count"}, stf_n - s0, se);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c0, p0, s0, e0;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {byte_o, byte_valid_o, sop_o, eop_o, pid_err_o, stuff_err_o}, 0);
    rst_ni = 1'b1;
    // R2: idle J yields nothing
    for (int i = 0; i < 20; i++) sym(1);
    chk("R2 idle no output", cap_n + eop_n + pid_n + stf_n, 0);

    // R3 R4 R6 R7 R8 R9: vector table
    foreach (VEC[v]) begin
      int len, extra;
      logic bad;
      len   = int'(VEC[v][39:36]);
      extra = int'(VEC[v][35:32]);
      for (int i = 0; i < 4; i++) pkt[i] = VEC[v][31-8*i -: 8];
      bad = (pkt[0][7:4] != ~pkt[0][3:0]);
      c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
      send_sync();
      for (int i = 0; i < len; i++) send_byte(pkt[i]);
      for (int i = 0; i < extra; i++) send_bit(i[0]);
      send_eop();
      check_pkt(bad ? "R6 bad pid" : (extra != 0 ? "R9 partial" : "R7 R8 R3 R4 packet"),
                c0, p0, s0, e0, bad ? 0 : len, bad ? 1 : 0, 0);
    end

    // R1: low-speed polarity
    ls = 1'b1;
    for (int i = 0; i < 4; i++) sym(1);
    pkt[0] = 8'hD2; pkt[1] = 8'h3C;
    c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
    send_sync(); send_byte(pkt[0]); send_byte(pkt[1]); send_eop();
    check_pkt("R1 low speed", c0, p0, s0, e0, 2, 0, 0);
    ls = 1'b0;
    for (int i = 0; i < 4; i++) sym(1);

    // R5 R4: six line 1s after sync (sync's final 1 counts) is a stuff error
    c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
    send_sync();
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0); send_raw(1'b1);
    send_eop();
    check_pkt("R5 R4 stuff error", c0, p0, s0, e0, 0, 0, 1);

    // R10: SE1 inside a packet
    c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
    send_sync(); send_byte(8'hD2); sym(3); send_byte(8'h11); send_eop();
    check_pkt("R10 SE1 abandon", c0, p0, s0, e0, 0, 0, 0);

    // R10: lone SE0 inside a packet
    c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
    send_sync(); send_byte(8'hD2); sym(0); sym(1); send_byte(8'h22); send_eop();
    check_pkt("R10 lone SE0 abandon", c0, p0, s0, e0, 0, 0, 0);

    // R8: decoding resumes after abandoned packets
    pkt[0] = 8'h69; pkt[1] = 8'h5A;
    c0 = cap_n; p0 = pid_n; s0 = stf_n; e0 = eop_n;
    send_sync(); send_byte(pkt[0]); send_byte(pkt[1]); send_eop();
    check_pkt("R8 recovery", c0, p0, s0, e0, 2, 0, 0);

    chk("R11 single-cycle pulses after strobe", pulse_bad, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule